// File: doc/BRIEF.md
# Display Power Request Register

This block is a host-visible register that switches three display supply rails: the panel supply, the bottom backlight and the top backlight. Each rail has a pair of request bits, one for off and one for on. The host posts requests by writing ones into a request register over a simple register bus. A read of the same address shows which requests are still outstanding. A second address holds a status word with the settled on/off state of each rail.

Outstanding requests are handed to an external power sequencer. Each rail has its own level request, a direction bit, a one-cycle accept strobe and a one-cycle done strobe. The panel-supply pair clears as soon as the sequencer accepts it, so a new panel request can be queued behind the one in flight. A backlight pair stays visible until its rail is done, so software can poll it for completion. While a backlight rail is in flight, writes to its pair are ignored. Every completion raises a single-cycle event output that can serve as an interrupt source. A parameter selects a single-backlight variant, in which the top rail is absent.

Top module: `disp_pwr_req`

## Requirements
- R1: After reset all rails are off. The request register reads 0, the status word reads 0, no seq_req bit is high and evt_done is low.
- R2: The request register sits at bus address REQ_ADDR (default 0) and the status word at STAT_ADDR (default 1). Request bits: bit0 panel off, bit1 panel on, bit2 bottom backlight off, bit3 bottom backlight on, bit4 top backlight off, bit5 top backlight on. Reading REQ_ADDR returns the pending bits at these positions, and the other bits read 0.
- R3: If both bits of one pair are written as 1 in the same write, only the off bit becomes pending and seq_on for that rail is 0. At most one bit of a pair is ever pending.
- R4: Zero bits in a write have no effect. A write of all zeros leaves every pending bit unchanged.
- R5: seq_req[r] is high while rail r (0 panel, 1 bottom, 2 top) has a pending request and is not in flight. seq_on[r] is 1 for an on request. An accept while seq_req[r] is high puts the rail in flight, and seq_req[r] drops on the next cycle.
- R6: The panel request bits (1:0) clear on the clock edge that samples the accept.
- R7: The backlight request bits (5:2) stay set while the rail is in flight. They clear on the edge that samples that rail's done strobe, which is the same edge on which its status bit updates.
- R8: The status word holds panel on at bit7, top backlight on at bit6 and bottom backlight on at bit5, with the other bits 0. On a done strobe for an in-flight rail, its status bit takes the direction that was accepted. At no other time does it change.
- R9: evt_done is high for exactly one cycle, starting on the edge that samples a done strobe of an in-flight rail.
- R10: A write to a backlight pair while that rail is in flight, or in the cycle its accept is sampled, is ignored.
- R11: With SINGLE_BL=1, request bits 5:4 have no effect. seq_req[2] stays low and status bit6 stays 0.
- R12: A panel request written while the panel rail is in flight stays pending and is requested once the rail is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| seq_req | output | 3 | Per-rail request to the sequencer |
| seq_on | output | 3 | Per-rail direction of the request (1 = on) |
| seq_acc | input | 3 | Per-rail accept strobe from the sequencer |
| seq_done | input | 3 | Per-rail completion strobe from the sequencer |
| evt_done | output | 1 | One-cycle completion event |

## Verification
The hardest situations to reach from the ports are the ones that need a rail to be in flight: a queued panel request sitting behind an accepted one, and a backlight write that has to be ignored while its rail is in flight. The bench reaches them by acting as the sequencer itself. It strobes accept, then performs bus writes before it strobes done. It then samples the pending bits, seq_req and the status word on the cycle after each strobe. A second instance built as the single-backlight variant shares the same stimulus, so top-rail writes can be compared between the two variants.

// File: rtl/disp_pwr_pkg.sv
package disp_pwr_pkg;
   localparam int RAILS    = 3;
   localparam int REQ_BITS = 2 * RAILS;

   typedef enum logic [1:0] {
      RAIL_PANEL = 2'd0,
      RAIL_BOT   = 2'd1,
      RAIL_TOP   = 2'd2
   } rail_e;

   // status word bit for each rail
   function automatic int stat_pos(input int rail);
      case (rail)
         0:       return 7;
         1:       return 5;
         default: return 6;
      endcase
   endfunction

   function automatic int off_pos(input int rail);
      return 2 * rail;
   endfunction

   function automatic int on_pos(input int rail);
      return 2 * rail + 1;
   endfunction
endpackage

// File: rtl/dpr_rail.sv
module dpr_rail #(
   parameter bit CLR_ON_ACC = 1'b0,
   parameter bit PRESENT    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_off,
   input  logic wr_on,
   input  logic acc,
   input  logic done,
   output logic pend_off,
   output logic pend_on,
   output logic req,
   output logic req_on,
   output logic busy,
   output logic state,
   output logic fin
);
   logic tgt_q;
   logic take;
   logic wr_ok;
   logic clr_now;

   assign req     = PRESENT & (pend_off | pend_on) & ~busy;
   assign req_on  = pend_on;
   assign take    = acc & req;
   assign fin     = done & busy;
   // panel pair may queue behind an in-flight request; backlight pairs are frozen
   assign wr_ok   = PRESENT & (CLR_ON_ACC | ~(busy | take));
   assign clr_now = CLR_ON_ACC ? take : fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_off <= 1'b0;
         pend_on  <= 1'b0;
         busy     <= 1'b0;
         tgt_q    <= 1'b0;
         state    <= 1'b0;
      end else begin
         if (take) begin
            busy  <= 1'b1;
            tgt_q <= pend_on;
         end
         if (fin) begin
            busy  <= 1'b0;
            state <= tgt_q;
         end
         if (clr_now) begin
            pend_off <= 1'b0;
            pend_on  <= 1'b0;
         end
         if (wr_ok && wr_off) begin
            pend_off <= 1'b1;
            pend_on  <= 1'b0;
         end else if (wr_ok && wr_on) begin
            pend_on  <= 1'b1;
            pend_off <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dpr_readmux.sv
module dpr_readmux
   import disp_pwr_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int REQ_ADDR  = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [REQ_BITS-1:0] pend,
   input  logic [RAILS-1:0]    state,
   output logic [DATA_W-1:0]   rdata
);
   logic [DATA_W-1:0] req_word;
   logic [DATA_W-1:0] stat_word;

   always_comb begin
      req_word = '0;
      req_word[REQ_BITS-1:0] = pend;
      stat_word = '0;
      for (int r = 0; r < RAILS; r++) begin
         stat_word[stat_pos(r)] = state[r];
      end
   end

   always_comb begin
      if (addr == ADDR_W'(REQ_ADDR))       rdata = req_word;
      else if (addr == ADDR_W'(STAT_ADDR)) rdata = stat_word;
      else                                 rdata = '0;
   end
endmodule

// File: rtl/disp_pwr_req.sv
module disp_pwr_req
   import disp_pwr_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int REQ_ADDR  = 0,
   parameter int STAT_ADDR = 1,
   parameter bit SINGLE_BL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [2:0]        seq_req,
   output logic [2:0]        seq_on,
   input  logic [2:0]        seq_acc,
   input  logic [2:0]        seq_done,
   output logic              evt_done
);
   localparam int MAX_ADDR = (1 << ADDR_W) - 1;

   generate
      if (DATA_W < 8) begin : g_chk_width
         $error("DATA_W must hold the status word");
      end
      if (REQ_ADDR == STAT_ADDR) begin : g_chk_addr
         $error("request and status addresses must differ");
      end
      if (REQ_ADDR > MAX_ADDR || STAT_ADDR > MAX_ADDR) begin : g_chk_range
         $error("register address exceeds ADDR_W");
      end
   endgenerate

   logic                wr_hit;
   logic [REQ_BITS-1:0] wr_bits;
   logic [REQ_BITS-1:0] pend_vec;
   logic [RAILS-1:0]    state_vec;
   logic [RAILS-1:0]    busy_vec;
   logic [RAILS-1:0]    fin_vec;
   logic                unused_hi;

   assign wr_hit    = bus_wr && (bus_addr == ADDR_W'(REQ_ADDR));
   assign wr_bits   = wr_hit ? bus_wdata[REQ_BITS-1:0] : '0;
   assign unused_hi = ^bus_wdata[DATA_W-1:REQ_BITS] ^ (^busy_vec);

   generate
      for (genvar r = 0; r < RAILS; r++) begin : g_rail
         dpr_rail #(
            .CLR_ON_ACC (r == int'(RAIL_PANEL)),
            .PRESENT    (!(SINGLE_BL && (r == int'(RAIL_TOP))))
         ) u_rail (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_off   (wr_bits[2*r]),
            .wr_on    (wr_bits[2*r+1]),
            .acc      (seq_acc[r]),
            .done     (seq_done[r]),
            .pend_off (pend_vec[2*r]),
            .pend_on  (pend_vec[2*r+1]),
            .req      (seq_req[r]),
            .req_on   (seq_on[r]),
            .busy     (busy_vec[r]),
            .state    (state_vec[r]),
            .fin      (fin_vec[r])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) evt_done <= 1'b0;
      else        evt_done <= |fin_vec;
   end

   dpr_readmux #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .REQ_ADDR  (REQ_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_readmux (
      .addr  (bus_addr),
      .pend  (pend_vec),
      .state (state_vec),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/dpr_chk.sv
module dpr_chk #(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int REQ_ADDR  = 0,
   parameter bit SINGLE_BL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [2:0]        seq_req,
   input logic [2:0]        seq_acc,
   input logic [2:0]        seq_done,
   input logic              evt_done,
   input logic [5:0]        pend,
   input logic [2:0]        state
);
   logic panel_wr;
   assign panel_wr = bus_wr && (bus_addr == ADDR_W'(REQ_ADDR)) && (bus_wdata[1:0] != 2'b00);

   AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend[0] && pend[1]) && !(pend[2] && pend[3]) && !(pend[4] && pend[5])); // R3

   generate
      for (genvar r = 0; r < 3; r++) begin : g_take
         AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_acc[r] && seq_req[r]) |=> !seq_req[r]); // R5
      end
   endgenerate

   AST_PANEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_acc[0] && seq_req[0] && !panel_wr) |=> (pend[1:0] == 2'b00)); // R6

   AST_BL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_acc[1] && seq_req[1]) |=> (pend[3:2] != 2'b00)); // R7

   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done == 3'b000) |=> $stable(state)); // R8

   AST_EVT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> ($past(seq_done) != 3'b000)); // R9

   generate
      if (SINGLE_BL) begin : g_single
         AST_TOP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
            !seq_req[2] && !state[2] && (pend[5:4] == 2'b00)); // R11
      end
   endgenerate
endmodule

bind disp_pwr_req dpr_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .REQ_ADDR  (REQ_ADDR),
   .SINGLE_BL (SINGLE_BL)
) u_dpr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .seq_req   (seq_req),
   .seq_acc   (seq_acc),
   .seq_done  (seq_done),
   .evt_done  (evt_done),
   .pend      (pend_vec),
   .state     (state_vec)
);

// File: tb/test_disp_pwr_req.sv
module test_disp_pwr_req;
   localparam int CLK_P = 10;
   localparam int RQ = 0;
   localparam int ST = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [2:0] seq_acc = 3'd0;
   logic [2:0] seq_done = 3'd0;
   logic [7:0] rdata, rdata_sb;
   logic [2:0] seq_req, seq_on, seq_req_sb, seq_on_sb;
   logic       evt, evt_sb;
   int         total = 0;
   int         bad = 0;

   always #(CLK_P/2) clk = ~clk;

   disp_pwr_req i_disp_pwr_req (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .seq_req(seq_req),
      .seq_on(seq_on), .seq_acc(seq_acc), .seq_done(seq_done), .evt_done(evt));

   disp_pwr_req #(.SINGLE_BL(1'b1)) i_disp_pwr_req_sb (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_sb), .seq_req(seq_req_sb),
      .seq_on(seq_on_sb), .seq_acc(seq_acc), .seq_done(seq_done), .evt_done(evt_sb));

   task automatic check(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic rd(input int a, output logic [7:0] v, output logic [7:0] vsb);
      bus_addr = 2'(a);
      #1;
      v = rdata;
      vsb = rdata_sb;
   endtask

   task automatic wr(input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = 2'(RQ); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'd0;
   endtask

   task automatic acc(input int r);
      seq_acc[r] = 1'b1;
      @(negedge clk);
      seq_acc = 3'd0;
   endtask

   task automatic done(input int r);
      seq_done[r] = 1'b1;
      @(negedge clk);
      seq_done = 3'd0;
   endtask

   task automatic t_reset;
      logic [7:0] v, vs;
      rd(RQ, v, vs); check("R1 request after reset", v, 0);
      rd(ST, v, vs); check("R1 status after reset", v, 0);
      check("R1 seq_req after reset", seq_req, 0);
      check("R1 evt after reset", evt, 0);
   endtask

   task automatic t_panel;
      logic [7:0] v, vs;
      wr(8'h02);
      rd(RQ, v, vs); check("R2 panel on pending bit1", v, 8'h02);
      check("R5 panel seq_req", seq_req, 3'b001);
      check("R5 panel seq_on", seq_on[0], 1);
      acc(0);
      rd(RQ, v, vs); check("R6 panel bits cleared on accept", v, 0);
      check("R5 seq_req drops after accept", seq_req, 0);
      wr(8'h01);
      rd(RQ, v, vs); check("R12 queued panel off pending", v, 8'h01);
      check("R12 no request while in flight", seq_req[0], 0);
      done(0);
      rd(ST, v, vs); check("R8 panel status bit7", v, 8'h80);
      check("R9 evt on completion", evt, 1);
      check("R12 queued request issued", seq_req[0], 1);
      check("R12 queued direction off", seq_on[0], 0);
      @(negedge clk);
      check("R9 evt one cycle", evt, 0);
      acc(0); done(0);
      rd(ST, v, vs); check("R8 panel status off", v, 0);
   endtask

   task automatic t_conflict;
      logic [7:0] v, vs;
      wr(8'h03);
      rd(RQ, v, vs); check("R3 panel off wins", v, 8'h01);
      check("R3 panel seq_on off", seq_on[0], 0);
      acc(0); done(0);
      rd(ST, v, vs); check("R3 panel stays off", v, 0);
      wr(8'h0C);
      rd(RQ, v, vs); check("R3 bottom off wins", v, 8'h04);
      acc(1); done(1);
      rd(RQ, v, vs); check("R3 bottom cleared", v, 0);
   endtask

   task automatic t_backlight;
      logic [7:0] v, vs;
      wr(8'h08);
      rd(RQ, v, vs); check("R2 bottom on bit3", v, 8'h08);
      wr(8'h00);
      rd(RQ, v, vs); check("R4 zero write keeps pending", v, 8'h08);
      acc(1);
      rd(RQ, v, vs); check("R7 bottom bit held in flight", v, 8'h08);
      check("R5 bottom seq_req drops", seq_req[1], 0);
      wr(8'h04);
      rd(RQ, v, vs); check("R10 write ignored in flight", v, 8'h08);
      rd(ST, v, vs); check("R8 status unchanged before done", v, 0);
      done(1);
      rd(RQ, v, vs); check("R7 bottom bit cleared on done", v, 0);
      rd(ST, v, vs); check("R7 bottom status bit5 same edge", v, 8'h20);
      check("R9 evt on backlight done", evt, 1);
   endtask

   task automatic t_top;
      logic [7:0] v, vs;
      wr(8'h20);
      rd(RQ, v, vs);
      check("R2 top on bit5", v, 8'h20);
      check("R11 single variant ignores top on", vs & 8'h30, 0);
      check("R11 single variant no top request", seq_req_sb[2], 0);
      check("R5 top seq_req", seq_req[2], 1);
      acc(2); done(2);
      rd(ST, v, vs);
      check("R8 top status bit6", v, 8'h60);
      check("R11 single variant status bit6 clear", vs & 8'h40, 0);
      wr(8'h10);
      rd(RQ, v, vs); check("R2 top off bit4", v, 8'h10);
      check("R11 single variant ignores top off", vs & 8'h30, 0);
      acc(2); done(2);
      rd(ST, v, vs); check("R8 top off", v, 8'h20);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_panel();
      t_conflict();
      t_backlight();
      t_top();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule